// File: doc/BRIEF.md
# Beam Permit Controller with Escalating Inhibit

This block is the central permit controller of a machine-protection system. A three-state sequencer takes the machine from a safe idle state (STANDBY), through an armed state (READY), to beam delivery (BEAM_ON). It moves on operating-mode change events, a configuration-complete flag, a beam-enable command and a per-channel trip vector that an upstream channel filter drives.

Any trip bit raises a fast inhibit (tier 1) in the same cycle. If the trip is still present after a fixed number of clock edges, a second, redundant inhibit (tier 2) also fires. Each channel has a saturating fault tally. A tally counts the trip onsets of its channel and returns to zero on its own after a quiet window in which that channel does not trip.

When all trips are gone and every tally is below a limit, the inhibits release by themselves. If any tally has reached the limit, the inhibits stay high until an operator reset arrives. That operator reset also zeroes the tallies.

Top module: `beam_permit_ctrl`

## Requirements
- R1: After reset, `state` is STANDBY (encoding 0), both inhibits are low and every tally is zero. The state encodings are STANDBY=0, READY=1 and BEAM_ON=2.
- R2: In STANDBY, `cfg_done` moves the state to READY at the next clock edge, unless `mode_evt` is high in the same cycle. In that case the state stays STANDBY.
- R3: In READY, `mode_evt` returns the state to STANDBY. Otherwise `beam_en` moves it to BEAM_ON, but only while `inhibit_t1` is low. If `inhibit_t1` is high, the state stays READY.
- R4: In BEAM_ON, any trip bit or `mode_evt` returns the state to STANDBY at the next clock edge.
- R5: `inhibit_t1` is high in the same cycle as any trip bit. It stays high after the trips clear, until a release takes place.
- R6: `inhibit_t2` rises after ESC_CYCLES consecutive clock edges at which some trip bit is high. If the trips clear before that, the timer restarts from zero and `inhibit_t2` stays low. `inhibit_t2` is never high without `inhibit_t1`.
- R7: Automatic release: at the first clock edge with all trip bits low and every tally below AUTO_LIMIT, both inhibits drop.
- R8: If any tally is at or above AUTO_LIMIT, the inhibits hold until `op_reset` is sampled high with all trip bits low. That release also zeroes every tally. An `op_reset` given while a trip bit is high has no effect.
- R9: A channel's tally, at bits [i*CNT_W +: CNT_W] of `fault_cnt`, rises by one at each edge where its trip bit is first sampled high. It saturates at 2^CNT_W-1.
- R10: A non-zero tally clears after QUIET_CYCLES consecutive clock edges with its trip bit low. Other channels' tallies are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_evt | input | 1 | Operating-mode change event |
| cfg_done | input | 1 | Configuration load complete |
| beam_en | input | 1 | Beam-enable command |
| op_reset | input | 1 | Operator recovery reset |
| trip | input | NCH | Per-channel trip flags from the channel filter |
| state | output | 2 | Sequencer state (0 STANDBY, 1 READY, 2 BEAM_ON) |
| inhibit_t1 | output | 1 | Fast first-tier inhibit |
| inhibit_t2 | output | 1 | Escalated second-tier inhibit |
| fault_cnt | output | NCH*CNT_W | Packed per-channel fault tallies |

## Verification
The sequencer is driven with:
- a config-done that collides with a mode event, which separates the priority of the two;
- a beam-enable with the inhibit low and again with it high, which shows that a held inhibit gates entry to BEAM_ON;
- a trip during BEAM_ON and a mode event during BEAM_ON, which exercise the two exits.

Trips of two lengths are applied, one edge short of the escalation delay and exactly at it. These separate the cancelled timer from the fired second tier.

Repeated short pulses on one channel drive the tally to the limit and then into saturation. This shows the automatic release turning into an operator-gated release. A single pulse followed by silence pins the quiet-window clearing to its exact edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_READY   = 2'd1,
    ST_BEAM_ON = 2'd2
  } bp_state_e;
endpackage

// File: rtl/bp_state_seq.sv
module bp_state_seq
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_evt,
  input  logic       cfg_done,
  input  logic       beam_en,
  input  logic       trip_any,
  input  logic       inhibit,
  output logic [1:0] state_o
);
  bp_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STANDBY: if (cfg_done && !mode_evt) st_d = ST_READY;
      ST_READY: begin
        if (mode_evt)                 st_d = ST_STANDBY;
        else if (beam_en && !inhibit) st_d = ST_BEAM_ON;
      end
      ST_BEAM_ON: if (trip_any || mode_evt) st_d = ST_STANDBY;
      default: st_d = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_STANDBY;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R4: a trip during beam delivery ends it at the next edge
  a_r4_trip_exit : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BEAM_ON && trip_any) |=> (st_q == ST_STANDBY));

  // R3: BEAM_ON is entered only from READY on beam_en with no inhibit
  a_r3_enter_gate : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BEAM_ON && $past(st_q) != ST_BEAM_ON) |->
      ($past(st_q) == ST_READY && $past(beam_en) && !$past(inhibit)));
endmodule

// File: rtl/bp_tier_inhibit.sv
module bp_tier_inhibit #(
  parameter int ESC_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_any,
  input  logic auto_ok,
  input  logic op_reset,
  output logic inhibit_t1,
  output logic inhibit_t2
);
  localparam int TW = $clog2(ESC_CYCLES + 1);
  localparam logic [TW-1:0] ELAST = TW'(ESC_CYCLES - 1);

  logic          hold_q, hold_d;
  logic          t2_q, t2_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          release_ok;

  assign release_ok = auto_ok || op_reset;

  always_comb begin
    hold_d = hold_q;
    t2_d   = t2_q;
    tmr_d  = tmr_q;
    if (trip_any) begin
      hold_d = 1'b1;
      if (!t2_q) begin
        if (tmr_q == ELAST) begin
          t2_d  = 1'b1;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
    end else begin
      tmr_d = '0;
      if (release_ok) begin
        hold_d = 1'b0;
        t2_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      t2_q   <= 1'b0;
      tmr_q  <= '0;
    end else begin
      hold_q <= hold_d;
      t2_q   <= t2_d;
      tmr_q  <= tmr_d;
    end
  end

  assign inhibit_t1 = trip_any | hold_q;
  assign inhibit_t2 = t2_q;

  // R6: the second tier never stands alone
  a_r6_t2_needs_t1 : assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_t2 |-> inhibit_t1);

  // R6: with no trip, an unfired second tier stays unfired
  a_r6_cancel : assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_any && !t2_q) |=> !t2_q);

  // R8: without a permitted release the hold persists
  a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !trip_any && !auto_ok && !op_reset) |=> hold_q);
endmodule

// File: rtl/bp_fault_tally.sv
module bp_fault_tally #(
  parameter int CNT_W        = 4,
  parameter int QUIET_CYCLES = 1000,
  parameter int AUTO_LIMIT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             below_lim_o
);
  localparam int QW = $clog2(QUIET_CYCLES + 1);
  localparam logic [QW-1:0]    QLAST = QW'(QUIET_CYCLES - 1);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM   = CNT_W'(AUTO_LIMIT);

  logic             trip_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [QW-1:0]    qcnt_q, qcnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    qcnt_d = qcnt_q;
    if (trip_i || cnt_q == '0) begin
      qcnt_d = '0;
    end else if (qcnt_q == QLAST) begin
      qcnt_d = '0;
      cnt_d  = '0;
    end else begin
      qcnt_d = qcnt_q + 1'b1;
    end
    if (trip_i && !trip_q && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    if (clear_i) begin
      cnt_d  = '0;
      qcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      cnt_q  <= '0;
      qcnt_q <= '0;
    end else begin
      trip_q <= trip_i;
      cnt_q  <= cnt_d;
      qcnt_q <= qcnt_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign below_lim_o = (cnt_q < LIM);

  // R9: a tally grows by at most one per edge
  a_r9_step : assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} > {1'b0, $past(cnt_q)}) |-> ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1));

  // R9: a full tally never wraps to a small non-zero value
  a_r9_saturate : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX) |=> (cnt_q == CMAX || cnt_q == '0));

  // R10: an active trip keeps a non-zero tally from clearing by itself
  a_r10_no_clear_while_trip : assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && cnt_q != '0 && !clear_i) |=> (cnt_q != '0));
endmodule

// File: rtl/beam_permit_ctrl.sv
module beam_permit_ctrl #(
  parameter int NCH          = 8,
  parameter int CNT_W        = 4,
  parameter int ESC_CYCLES   = 2500,
  parameter int QUIET_CYCLES = 100000,
  parameter int AUTO_LIMIT   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_evt,
  input  logic                 cfg_done,
  input  logic                 beam_en,
  input  logic                 op_reset,
  input  logic [NCH-1:0]       trip,
  output logic [1:0]           state,
  output logic                 inhibit_t1,
  output logic                 inhibit_t2,
  output logic [NCH*CNT_W-1:0] fault_cnt
);
  logic           trip_any;
  logic           auto_ok;
  logic           tally_clear;
  logic [NCH-1:0] below_lim;

  assign trip_any    = |trip;
  assign tally_clear = op_reset && !trip_any;
  assign auto_ok     = &below_lim;

  bp_state_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_evt (mode_evt),
    .cfg_done (cfg_done),
    .beam_en  (beam_en),
    .trip_any (trip_any),
    .inhibit  (inhibit_t1),
    .state_o  (state)
  );

  bp_tier_inhibit #(.ESC_CYCLES(ESC_CYCLES)) u_tier (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_any   (trip_any),
    .auto_ok    (auto_ok),
    .op_reset   (op_reset),
    .inhibit_t1 (inhibit_t1),
    .inhibit_t2 (inhibit_t2)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    bp_fault_tally #(
      .CNT_W        (CNT_W),
      .QUIET_CYCLES (QUIET_CYCLES),
      .AUTO_LIMIT   (AUTO_LIMIT)
    ) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .trip_i      (trip[i]),
      .clear_i     (tally_clear),
      .cnt_o       (fault_cnt[i*CNT_W +: CNT_W]),
      .below_lim_o (below_lim[i])
    );
  end
endmodule

// File: tb/beam_permit_ctrl_test.sv
`timescale 1ns/1ps
module beam_permit_ctrl_test;
  localparam int NCH = 4, CW = 3, ESC = 8, QUIET = 20, LIM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_evt = 0, cfg_done = 0, beam_en = 0, op_reset = 0;
  logic [NCH-1:0] trip = '0;
  logic [1:0] state;
  logic inhibit_t1, inhibit_t2;
  logic [NCH*CW-1:0] fault_cnt;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  beam_permit_ctrl #(.NCH(NCH), .CNT_W(CW), .ESC_CYCLES(ESC),
                     .QUIET_CYCLES(QUIET), .AUTO_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .mode_evt(mode_evt), .cfg_done(cfg_done),
    .beam_en(beam_en), .op_reset(op_reset), .trip(trip), .state(state),
    .inhibit_t1(inhibit_t1), .inhibit_t2(inhibit_t2), .fault_cnt(fault_cnt));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt(int ch);
    return int'(fault_cnt[ch*CW +: CW]);
  endfunction

  task automatic clean_up();
    trip = '0; mode_evt = 0; cfg_done = 0; beam_en = 0;
    op_reset = 1; tick(); op_reset = 0;
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 t1", inhibit_t1, 0);
    chk("R1 t2", inhibit_t2, 0);
    chk("R1 counts", fault_cnt, 0);
  endtask

  task automatic t_sequence();
    cfg_done = 1; mode_evt = 1; tick();
    chk("R2 mode_evt beats cfg_done", state, 0);
    mode_evt = 0; tick(); cfg_done = 0;
    chk("R2 to READY", state, 1);
    mode_evt = 1; tick(); mode_evt = 0;
    chk("R3 mode_evt in READY", state, 0);
    cfg_done = 1; tick(); cfg_done = 0;
    beam_en = 1; tick(); beam_en = 0;
    chk("R3 to BEAM_ON", state, 2);
    mode_evt = 1; tick(); mode_evt = 0;
    chk("R4 mode_evt exits BEAM_ON", state, 0);
  endtask

  task automatic t_trip_short();
    cfg_done = 1; tick(); cfg_done = 0;
    beam_en = 1; tick(); beam_en = 0;
    chk("R3 BEAM_ON again", state, 2);
    trip[1] = 1; #1;
    chk("R5 t1 same cycle", inhibit_t1, 1);
    tick();
    chk("R4 trip exits BEAM_ON", state, 0);
    chk("R9 ch1 count", cnt(1), 1);
    tick(ESC - 2);
    chk("R6 no t2 one edge short", inhibit_t2, 0);
    trip[1] = 0; #1;
    chk("R5 t1 held after trip clears", inhibit_t1, 1);
    tick();
    chk("R7 auto release t1", inhibit_t1, 0);
    trip[1] = 1; tick(ESC - 1); trip[1] = 0; tick();
    chk("R6 timer restarted, t2 low", inhibit_t2, 0);
    clean_up();
  endtask

  task automatic t_escalate();
    cfg_done = 1; tick(); cfg_done = 0;
    trip[2] = 1; tick(ESC - 1);
    chk("R6 t2 before delay", inhibit_t2, 0);
    beam_en = 1; tick(); beam_en = 0;
    chk("R6 t2 after delay", inhibit_t2, 1);
    chk("R3 inhibit blocks beam_en", state, 1);
    trip[2] = 0; tick();
    chk("R7 auto release t2", inhibit_t2, 0);
    chk("R7 auto release t1", inhibit_t1, 0);
    clean_up();
  endtask

  task automatic t_operator();
    for (int p = 0; p < LIM; p++) begin
      trip[0] = 1; tick(); trip[0] = 0; tick();
    end
    chk("R9 ch0 count at limit", cnt(0), LIM);
    tick(3);
    chk("R8 t1 held at limit", inhibit_t1, 1);
    trip[3] = 1; op_reset = 1; tick(); op_reset = 0;
    chk("R8 op_reset ignored during trip", cnt(0), LIM);
    trip[3] = 0; tick();
    chk("R8 still held", inhibit_t1, 1);
    op_reset = 1; tick(); op_reset = 0;
    chk("R8 op_reset releases t1", inhibit_t1, 0);
    chk("R8 op_reset clears counts", fault_cnt, 0);
  endtask

  task automatic t_quiet();
    trip[1] = 1; tick(); trip[1] = 0;
    chk("R9 ch1 single pulse", cnt(1), 1);
    tick(QUIET - 1);
    chk("R10 still counted before window", cnt(1), 1);
    tick();
    chk("R10 cleared after window", cnt(1), 0);
  endtask

  task automatic t_saturate();
    for (int p = 0; p < 9; p++) begin
      trip[2] = 1; tick(); trip[2] = 0; tick();
    end
    chk("R9 saturates", cnt(2), 7);
    chk("R10 other channel untouched", cnt(0), 0);
    clean_up();
    chk("R8 cleanup", fault_cnt, 0);
  endtask

  initial begin
    #1;
    t_reset();
    tick(2); rst_n = 1; tick();
    t_reset();
    t_sequence();
    t_trip_short();
    t_escalate();
    t_operator();
    t_quiet();
    t_saturate();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule